// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the request and priority core of an eight-input interrupt controller. Request lines come in already synchronised to the block clock. They are captured into a pending register, either on a rising transition or on a high level. A per-channel mask filters the pending levels. The best remaining level is compared against the levels already in service, and the block raises `irq` when a pending level should preempt. An acknowledge strobe moves the winning level from pending to in-service and reports its number. Decoded command strobes then retire in-service levels and reorder the priority.

Priority runs as a ring. One level is named the lowest, and the level after it, modulo the level count, is the highest. The lowest level can be set directly, or moved on an end-of-interrupt to the level that has just been retired. A special mask mode lets any unmasked level interrupt whatever is in service. The bus interface, vector formatting and cascade control sit outside this block.

Top module: `irq_prio_core`

## Requirements
- R1: After reset, and one cycle after an `init` strobe, pending, in-service and mask are all zero, special mask mode is off, `low_level` is 7 and `irq` is low.
- R2: Priority runs from `low_level`+1 (highest) upward modulo 8 to `low_level` (lowest). A `cmd_setpri` strobe loads `low_level` from `cmd_level`; for example, `low_level`=5 makes level 6 the highest.
- R3: With special mask mode off, an in-service level blocks pending levels of the same or lower priority, while a higher-priority pending level still raises `irq`.
- R4: `cmd_eoi` with `cmd_specific`=0 clears the in-service bit of highest current priority. `cmd_eoi` with `cmd_specific`=1 clears the in-service bit numbered `cmd_level`.
- R5: `cmd_eoi` with `cmd_rotate`=1 also makes the retired level the lowest. For a specific command that level is `cmd_level`; for a non-specific command it is the level that was cleared.
- R6: With special mask mode on (`smm_wr` with `smm_val`=1), a mask bit inhibits only its own level, and any unmasked pending level that is not itself in service raises `irq`. In this mode a non-specific end-of-interrupt skips in-service bits whose mask bit is set.
- R7: With `level_trig`=0, a request is captured only on a 0-to-1 transition, and a line held high does not request again after it is acknowledged. With `level_trig`=1, the pending bit follows the line level.
- R8: `init` sets the edge history of every line to high, so in edge mode a line that is high through `init` must fall and rise again before it can request.
- R9: The mask never changes the `pending` read-back. A masked level never raises `irq`.
- R10: `ack` while `irq` is high sets the winning level's in-service bit, clears its pending bit and loads its number into `ack_level`, all at the same edge. During that cycle no new requests are captured, and a rise that occurs then is taken on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init | input | 1 | Initialisation strobe |
| level_trig | input | 1 | 1 = level capture, 0 = edge capture |
| req | input | 8 | Synchronised request lines |
| mask_wr | input | 1 | Load mask register |
| mask_data | input | 8 | New mask, 1 = channel inhibited |
| smm_wr | input | 1 | Load special mask mode flag |
| smm_val | input | 1 | Special mask mode value |
| ack | input | 1 | Acknowledge strobe |
| cmd_eoi | input | 1 | End-of-interrupt strobe |
| cmd_setpri | input | 1 | Set lowest-priority level strobe |
| cmd_specific | input | 1 | End-of-interrupt targets `cmd_level` |
| cmd_rotate | input | 1 | End-of-interrupt also rotates priority |
| cmd_level | input | 3 | Level operand of commands |
| irq | output | 1 | Interrupt request to the processor |
| ack_level | output | 3 | Level taken by the last accepted acknowledge |
| pending | output | 8 | Pending register read-back |
| in_service | output | 8 | In-service register read-back |
| mask_state | output | 8 | Mask register read-back |
| low_level | output | 3 | Current lowest-priority level |

## Verification
The resolver is driven with request sets that straddle the rotation point, with masks that hide the nominal winner, and with a fully masked set. Together these separate a correct ring ordering from a fixed order and from one that ignores the mask. Nested cases hold one level in service and then raise a lower and a higher request, which shows blocking and preemption apart. The same in-service state is retired under both mask modes, so a non-specific end-of-interrupt that ignores special mask mode gives a different result. Edge tests hold a line high across `init` and across an acknowledge, and raise a second line in the acknowledge cycle, which exposes lost edges and repeated capture.

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
  parameter int N  = 8,            // level count, power of two
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          level_trig,
  input  logic [N-1:0]  req,
  input  logic          mask_wr,
  input  logic [N-1:0]  mask_data,
  input  logic          smm_wr,
  input  logic          smm_val,
  input  logic          ack,
  input  logic          cmd_eoi,
  input  logic          cmd_setpri,
  input  logic          cmd_specific,
  input  logic          cmd_rotate,
  input  logic [LW-1:0] cmd_level,
  output logic          irq,
  output logic [LW-1:0] ack_level,
  output logic [N-1:0]  pending,
  output logic [N-1:0]  in_service,
  output logic [N-1:0]  mask_state,
  output logic [LW-1:0] low_level
);

  logic [N-1:0]  pend_q, isr_q, mask_q, hist_q;
  logic [LW-1:0] low_q, ack_q;
  logic          smm_q;

  function automatic logic [N-1:0] rot_dn(input logic [N-1:0] v, input logic [LW-1:0] s);
    logic [LW-1:0] k;
    rot_dn = '0;
    for (int i = 0; i < N; i++) begin
      k = LW'(i) + s;
      rot_dn[i] = v[k];
    end
  endfunction

  function automatic logic [LW:0] first_set(input logic [N-1:0] v);
    first_set = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) first_set = {1'b1, LW'(i)};
  endfunction

  wire [LW-1:0] hp = low_q + 1'b1;

  wire [N-1:0] cand = pend_q & ~mask_q & (smm_q ? ~isr_q : '1);
  wire [N-1:0] blk  = smm_q ? '0 : isr_q;
  wire [N-1:0] eov  = smm_q ? (isr_q & ~mask_q) : isr_q;

  wire [LW:0] cf = first_set(rot_dn(cand, hp));
  wire [LW:0] bf = first_set(rot_dn(blk, hp));
  wire [LW:0] ef = first_set(rot_dn(eov, hp));

  wire [LW-1:0] win  = cf[LW-1:0] + hp;
  wire [LW-1:0] etgt = ef[LW-1:0] + hp;

  assign irq = cf[LW] && (!bf[LW] || (cf[LW-1:0] < bf[LW-1:0]));

  wire          take    = ack && irq;
  wire [N-1:0]  set_vec = take ? (N'(1) << win) : '0;
  wire [LW-1:0] eoi_lvl = cmd_specific ? cmd_level : etgt;
  wire          eoi_hit = cmd_eoi && (cmd_specific || ef[LW]);
  wire [N-1:0]  clr_vec = eoi_hit ? (N'(1) << eoi_lvl) : '0;

  logic [LW-1:0] low_nx;
  always_comb begin
    low_nx = low_q;
    if (cmd_setpri)                       low_nx = cmd_level;
    else if (eoi_hit && cmd_rotate)       low_nx = eoi_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      isr_q  <= '0;
      mask_q <= '0;
      hist_q <= '1;
      low_q  <= LW'(N - 1);
      ack_q  <= '0;
      smm_q  <= 1'b0;
    end else if (init) begin
      pend_q <= '0;
      isr_q  <= '0;
      mask_q <= '0;
      hist_q <= '1;
      low_q  <= LW'(N - 1);
      smm_q  <= 1'b0;
    end else begin
      if (ack) begin
        pend_q <= pend_q & ~set_vec;
      end else begin
        pend_q <= level_trig ? req : (pend_q | (req & ~hist_q));
        hist_q <= req;
      end
      isr_q <= (isr_q | set_vec) & ~clr_vec;
      low_q <= low_nx;
      if (take)    ack_q  <= win;
      if (mask_wr) mask_q <= mask_data;
      if (smm_wr)  smm_q  <= smm_val;
    end
  end

  assign ack_level  = ack_q;
  assign pending    = pend_q;
  assign in_service = isr_q;
  assign mask_state = mask_q;
  assign low_level  = low_q;

  a_r1_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (pending == '0 && in_service == '0 && mask_state == '0 && low_level == LW'(N - 1)));

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pending & ~mask_state) != '0));

  a_r10_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !init && !cmd_eoi) |=> (in_service[$past(win)] && !pending[$past(win)]));

  a_r4_specific_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_eoi && cmd_specific && !ack && !init) |=> !in_service[$past(cmd_level)]);

  a_r5_rotate_specific: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_eoi && cmd_specific && cmd_rotate && !cmd_setpri && !init) |=> (low_level == $past(cmd_level)));

endmodule

// File: tb/irq_prio_core_test.sv
module irq_prio_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init = 0, level_trig = 1, mask_wr = 0, smm_wr = 0, smm_val = 0, ack = 0;
  logic       cmd_eoi = 0, cmd_setpri = 0, cmd_specific = 0, cmd_rotate = 0;
  logic [2:0] cmd_level = 0;
  logic [7:0] req = 0, mask_data = 0;
  logic       irq;
  logic [2:0] ack_level, low_level;
  logic [7:0] pending, in_service, mask_state;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_core uut (.*);

  // {low[22:20], req[19:12], mask[11:4], irq[3], level[2:0]}
  localparam logic [22:0] VEC [8] = '{
    {3'd7, 8'h28, 8'h00, 1'b1, 3'd3},
    {3'd2, 8'h03, 8'h00, 1'b1, 3'd0},
    {3'd5, 8'h61, 8'h00, 1'b1, 3'd6},
    {3'd0, 8'h81, 8'h00, 1'b1, 3'd7},
    {3'd7, 8'h0C, 8'h04, 1'b1, 3'd3},
    {3'd7, 8'h10, 8'h10, 1'b0, 3'd0},
    {3'd3, 8'h18, 8'h00, 1'b1, 3'd4},
    {3'd6, 8'hFF, 8'h00, 1'b1, 3'd7}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_init();
    init = 1; tick(); init = 0;
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic setpri(input logic [2:0] l);
    cmd_setpri = 1; cmd_level = l; tick(); cmd_setpri = 0;
  endtask

  task automatic setmask(input logic [7:0] m);
    mask_wr = 1; mask_data = m; tick(); mask_wr = 0;
  endtask

  task automatic eoi(input logic spec, input logic rot, input logic [2:0] l);
    cmd_eoi = 1; cmd_specific = spec; cmd_rotate = rot; cmd_level = l;
    tick();
    cmd_eoi = 0; cmd_specific = 0; cmd_rotate = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 reset pending", pending, 8'h00);
    chk("R1 reset in_service", in_service, 8'h00);
    chk("R1 reset mask", mask_state, 8'h00);
    chk("R1 reset low_level", low_level, 3'd7);
    chk("R1 reset irq", irq, 1'b0);

    // R2 ring priority table
    level_trig = 1;
    for (int i = 0; i < 8; i++) begin
      do_init();
      setpri(VEC[i][22:20]);
      setmask(VEC[i][11:4]);
      req = VEC[i][19:12];
      tick(); tick();
      chk($sformatf("R2 vec%0d irq", i), irq, VEC[i][3]);
      if (VEC[i][3]) begin
        do_ack();
        chk($sformatf("R2 vec%0d ack_level", i), ack_level, VEC[i][2:0]);
        chk($sformatf("R10 vec%0d in_service", i), in_service, 8'h01 << VEC[i][2:0]);
      end
      req = 0;
    end

    // R3 nesting
    do_init();
    req = 8'h10; tick(); tick();
    do_ack();
    chk("R3 isr after ack", in_service, 8'h10);
    req = 8'h50; tick(); tick();
    chk("R3 lower blocked", irq, 1'b0);
    req = 8'h54; tick(); tick();
    chk("R3 higher preempts", irq, 1'b1);
    do_ack();
    chk("R3 preempt level", ack_level, 3'd2);
    chk("R3 nested isr", in_service, 8'h14);

    // R4 end-of-interrupt
    eoi(0, 0, 3'd0);
    chk("R4 nonspecific clears highest", in_service, 8'h10);
    eoi(1, 0, 3'd4);
    chk("R4 specific clears named", in_service, 8'h00);
    chk("R4 no rotate keeps low", low_level, 3'd7);

    // R5 rotation on end-of-interrupt
    req = 0;
    do_init();
    req = 8'h08; tick(); tick();
    do_ack();
    req = 0;
    eoi(0, 1, 3'd0);
    chk("R5 nonspecific rotate low", low_level, 3'd3);
    chk("R5 nonspecific rotate isr", in_service, 8'h00);
    req = 8'h18; tick(); tick();
    do_ack();
    chk("R5 rotated winner", ack_level, 3'd4);
    req = 0;
    eoi(1, 1, 3'd6);
    chk("R5 specific rotate low", low_level, 3'd6);

    // R6 special mask mode
    do_init();
    req = 8'h02; tick(); tick();
    do_ack();
    chk("R6 first isr", in_service, 8'h02);
    req = 8'h22; tick(); tick();
    chk("R6 nested blocks lower", irq, 1'b0);
    smm_wr = 1; smm_val = 1; tick(); smm_wr = 0;
    chk("R6 smm lets lower through", irq, 1'b1);
    do_ack();
    chk("R6 smm ack level", ack_level, 3'd5);
    chk("R6 smm isr", in_service, 8'h22);
    setmask(8'h02);
    eoi(0, 0, 3'd0);
    chk("R6 nonspecific skips masked", in_service, 8'h02);

    // R1 init clears
    req = 0;
    do_init();
    chk("R1 init mask", mask_state, 8'h00);
    chk("R1 init isr", in_service, 8'h00);
    chk("R1 init low", low_level, 3'd7);

    // R9 mask vs read-back
    setmask(8'hFF);
    req = 8'h04; tick(); tick();
    chk("R9 pending unmasked readback", pending, 8'h04);
    chk("R9 masked no irq", irq, 1'b0);

    // R7 / R8 edge capture
    level_trig = 0;
    req = 8'h01;
    do_init();
    tick(); tick();
    chk("R8 held line not captured", pending, 8'h00);
    req = 8'h00; tick();
    req = 8'h01; tick();
    chk("R7 rising edge captured", pending, 8'h01);
    do_ack();
    chk("R7 ack isr", in_service, 8'h01);
    tick(); tick(); tick();
    chk("R7 held high no repeat", pending, 8'h00);

    // R10 freeze in ack cycle
    eoi(1, 0, 3'd0);
    req = 8'h09; tick();
    chk("R7 second edge", pending, 8'h08);
    ack = 1; req = 8'h0B; tick(); ack = 0;
    chk("R10 ack cycle frozen", pending, 8'h00);
    chk("R10 ack level", ack_level, 3'd3);
    tick();
    chk("R10 deferred edge taken", pending, 8'h02);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule